// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the 64-byte type-0 configuration header of one PCI function and answers configuration reads and writes of one, two or four bytes at a byte offset. Identification fields, class codes and the power-up contents of the writable registers are fixed by parameters. Each register accepts writes only at the access widths listed below, and every other write leaves the header unchanged. Reads return the little-endian byte image of the header, registered, one cycle after the read strobe.

Each of the six base address registers has its own size parameter. Writing all ones to a base register starts the sizing handshake, and the register then reads back the size mask. Its read-only space-type bits stay as they were, so software can tell I/O windows from memory windows. Any other word write to a base register stores a new window base. When that base is nonzero, the block emits a one-cycle pulse so that the address decoder can refresh its ranges. The expansion ROM register has its own sizing value. A host bridge places the block behind its configuration decoder and wires the pulse to its range logic.

Top module: `cfg_hdr_top`

## Requirements
- R1: After reset, the read-only fields come from parameters and never change: vendor ID (offset 0x00), device ID (0x02), revision, programming interface, subclass, class (0x08 to 0x0B), header type (0x0E), self-test byte (0x0F), cardbus pointer (0x28), subsystem vendor and subsystem IDs (0x2C, 0x2E), interrupt pin, minimum grant and maximum latency (0x3D to 0x3F). The writable registers reset to their own parameters.
- R2: cfgSize selects the access width: 0 is a byte, 1 is a halfword, 2 is a word and 3 is invalid. A read returns that many bytes of the little-endian header image, starting at cfgAddr, in cfgRdata[7:0] upward, with the unused upper bits zero. cfgRdValid is high for exactly the cycle after each cycle with cfgRdEn.
- R3: Any access at offset 0x40 or above, a halfword at an odd offset, a word at an offset that is not a multiple of 4, and any access with size code 3 all read as zero, and a write of this kind changes nothing.
- R4: A byte write updates only the addressed byte, and only at interrupt line (0x3C), cache line size (0x0C) or latency timer (0x0D). A byte write to any other offset is ignored.
- R5: A halfword write at 0x04 loads the command register and one at 0x06 loads the status register. A halfword write at 0x0C loads cache line size from the low byte and leaves latency timer unchanged. Any other halfword write is ignored.
- R6: A word write at 0x04 loads command from bits 15:0 and leaves status unchanged. Word writes are also accepted by the six base registers (0x10, 0x14, ... 0x24) and by the expansion ROM register (0x30). Any other word write is ignored.
- R7: The space-type bits of a base register never change. If its bit 0 is 1, the register maps I/O and bits 1:0 are read-only. If its bit 0 is 0, it maps memory and bits 3:0 are read-only.
- R8: A word write of 0xFFFFFFFF to base register n loads ~(size_n - 1) into its writable bits and keeps its type bits. A size of 0 therefore reads back as only the type bits.
- R9: Any other word write to a base register stores the written value in the writable bits. rangeChg is high for the single cycle after the write edge exactly when the resulting writable bits are nonzero. A sizing write, a write that leaves the base at zero, and any write to another register produce no pulse.
- R10: A word write of 0xFFFFFFFE to the expansion ROM register makes it read 0xFFFFFFFF. Any other word write there is stored unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAddr | input | 8 | Byte offset of the access |
| cfgSize | input | 2 | Access width code (0 byte, 1 halfword, 2 word, 3 invalid) |
| cfgWdata | input | 32 | Write data, right-aligned |
| cfgWrEn | input | 1 | Write strobe |
| cfgRdEn | input | 1 | Read strobe |
| cfgRdata | output | 32 | Read data, registered |
| cfgRdValid | output | 1 | Read data valid, one cycle after cfgRdEn |
| rangeChg | output | 1 | One-cycle pulse on a nonzero base-register update |

## Verification
Directed cases write to every width-offset pair that accepts writes. They also write to read-only neighbours, at misaligned offsets and above the header, and each write is followed by a read of the whole surrounding word. A write that lands on the wrong register, or a byte lane that spills into a neighbour, therefore shows up at once. The base registers are tried with sizing writes on I/O, memory and zero-size windows, with address writes whose writable part is zero or nonzero, and with ROM sizing and plain values. These cases tell the type-bit masks apart and show whether the pulse follows sizing or address writes. A seeded random stream then mixes all offsets, widths and the two sizing patterns against a byte-level header model, and checks both read data and the pulse after every write.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } accSize_e;

  // Header layout is fixed by the bus standard: six base registers.
  localparam int NUM_BARS = 6;
  localparam int HDR_BYTES = 64;
  localparam int OFF_W = $clog2(HDR_BYTES);

  localparam logic [OFF_W-1:0] OFF_COMMAND   = 6'h04;
  localparam logic [OFF_W-1:0] OFF_STATUS    = 6'h06;
  localparam logic [OFF_W-1:0] OFF_CACHELINE = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_LATENCY   = 6'h0D;
  localparam logic [OFF_W-1:0] OFF_BAR_BASE  = 6'h10;
  localparam logic [OFF_W-1:0] OFF_ROM       = 6'h30;
  localparam logic [OFF_W-1:0] OFF_INTLINE   = 6'h3C;

  localparam logic [31:0] BAR_SIZING_KEY = 32'hFFFF_FFFF;
  localparam logic [31:0] ROM_SIZING_KEY = 32'hFFFF_FFFE;
  localparam logic [31:0] IO_RO_MASK     = 32'h0000_0003;
  localparam logic [31:0] MEM_RO_MASK    = 32'h0000_000F;

  // Strobes from the decode control to the register datapath.
  typedef struct packed {
    logic                 wrIntLine;
    logic                 wrCacheLine;
    logic                 wrLatency;
    logic                 wrCommand;
    logic                 wrStatus;
    logic                 wrRom;
    logic [NUM_BARS-1:0]  wrBar;
    logic                 rdFire;
    logic                 rdOk;
    logic [1:0]           rdSize;
    logic [OFF_W-1:0]     rdOff;
  } hdrStrobe_t;

endpackage

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_hdr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [1:0]        cfgSize,
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  output hdrStrobe_t        strobe
);

  localparam int HI_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0] off;
  logic             inHdr;
  logic             aligned;
  logic             accOk;
  logic             wrByte;
  logic             wrHalf;
  logic             wrWord;

  assign off   = cfgAddr[OFF_W-1:0];
  assign inHdr = (cfgAddr[ADDR_W-1:OFF_W] == {HI_W{1'b0}});

  always_comb begin
    case (accSize_e'(cfgSize))
      SZ_BYTE: aligned = 1'b1;
      SZ_HALF: aligned = ~off[0];
      SZ_WORD: aligned = (off[1:0] == 2'b00);
      default: aligned = 1'b0;
    endcase
  end

  assign accOk  = inHdr & aligned;
  assign wrByte = cfgWrEn & accOk & (cfgSize == SZ_BYTE);
  assign wrHalf = cfgWrEn & accOk & (cfgSize == SZ_HALF);
  assign wrWord = cfgWrEn & accOk & (cfgSize == SZ_WORD);

  always_comb begin
    strobe.wrIntLine   = wrByte & (off == OFF_INTLINE);
    strobe.wrLatency   = wrByte & (off == OFF_LATENCY);
    strobe.wrCacheLine = (wrByte | wrHalf) & (off == OFF_CACHELINE);
    strobe.wrStatus    = wrHalf & (off == OFF_STATUS);
    strobe.wrCommand   = (wrHalf | wrWord) & (off == OFF_COMMAND);
    strobe.wrRom       = wrWord & (off == OFF_ROM);
    strobe.rdFire      = cfgRdEn;
    strobe.rdOk        = cfgRdEn & accOk;
    strobe.rdSize      = cfgSize;
    strobe.rdOff       = off;
  end

  for (genvar i = 0; i < NUM_BARS; i++) begin : gBarDec
    localparam logic [OFF_W-1:0] BAR_OFF = OFF_BAR_BASE + OFF_W'(4 * i);
    assign strobe.wrBar[i] = wrWord & (off == BAR_OFF);
  end

endmodule

// File: rtl/cfg_hdr_dpath.sv
module cfg_hdr_dpath
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID     = 16'h0001,
  parameter logic [7:0]  REVISION      = 8'h00,
  parameter logic [7:0]  PROG_IF       = 8'h00,
  parameter logic [7:0]  SUBCLASS      = 8'h00,
  parameter logic [7:0]  CLASS_CODE    = 8'h00,
  parameter logic [7:0]  HEADER_TYPE   = 8'h00,
  parameter logic [7:0]  SELF_TEST     = 8'h00,
  parameter logic [31:0] CARDBUS_PTR   = 32'h0,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h0,
  parameter logic [15:0] SUBSYS_ID     = 16'h0,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [7:0]  MIN_GRANT     = 8'h00,
  parameter logic [7:0]  MAX_LATENCY   = 8'h00,
  parameter logic [15:0] COMMAND_INIT  = 16'h0,
  parameter logic [15:0] STATUS_INIT   = 16'h0,
  parameter logic [7:0]  CACHE_INIT    = 8'h00,
  parameter logic [7:0]  LATENCY_INIT  = 8'h00,
  parameter logic [7:0]  INTLINE_INIT  = 8'h00,
  parameter logic [31:0] ROM_INIT      = 32'h0,
  parameter logic [NUM_BARS-1:0][31:0] BAR_INIT = '0,
  parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  hdrStrobe_t  strobe,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  output logic        cfgRdValid,
  output logic        rangeChg
);

  logic [15:0] commandQ;
  logic [15:0] statusQ;
  logic [7:0]  cacheQ;
  logic [7:0]  latencyQ;
  logic [7:0]  intLineQ;
  logic [31:0] romQ;

  logic                          barSizing;
  logic [NUM_BARS-1:0]           barChg;
  logic [NUM_BARS-1:0][31:0]     barImg;

  assign barSizing = (cfgWdata == BAR_SIZING_KEY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commandQ <= COMMAND_INIT;
      statusQ  <= STATUS_INIT;
      cacheQ   <= CACHE_INIT;
      latencyQ <= LATENCY_INIT;
      intLineQ <= INTLINE_INIT;
      romQ     <= ROM_INIT;
    end else begin
      if (strobe.wrCommand)   commandQ <= cfgWdata[15:0];
      if (strobe.wrStatus)    statusQ  <= cfgWdata[15:0];
      if (strobe.wrCacheLine) cacheQ   <= cfgWdata[7:0];
      if (strobe.wrLatency)   latencyQ <= cfgWdata[7:0];
      if (strobe.wrIntLine)   intLineQ <= cfgWdata[7:0];
      if (strobe.wrRom)       romQ     <= (cfgWdata == ROM_SIZING_KEY) ? 32'hFFFF_FFFF : cfgWdata;
    end
  end

  for (genvar i = 0; i < NUM_BARS; i++) begin : gBar
    localparam logic [31:0] SIZE_MASK = ~(BAR_SIZE[i] - 32'd1);
    logic [31:0] barQ;
    logic [31:0] roMask;
    logic [31:0] nextVal;

    assign roMask = barQ[0] ? IO_RO_MASK : MEM_RO_MASK;

    always_comb begin
      if (barSizing) nextVal = (SIZE_MASK & ~roMask) | (barQ & roMask);
      else           nextVal = (cfgWdata & ~roMask) | (barQ & roMask);
    end

    always_ff @(posedge clk) begin
      if (!rstN)                barQ <= BAR_INIT[i];
      else if (strobe.wrBar[i]) barQ <= nextVal;
    end

    assign barChg[i] = strobe.wrBar[i] & ~barSizing & ((nextVal & ~roMask) != 32'd0);
    assign barImg[i] = barQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rangeChg <= 1'b0;
    else       rangeChg <= |barChg;
  end

  // Little-endian byte image of the header.
  logic [HDR_BYTES-1:0][7:0] img;

  always_comb begin
    img        = '0;
    img[1:0]   = VENDOR_ID;
    img[3:2]   = DEVICE_ID;
    img[5:4]   = commandQ;
    img[7:6]   = statusQ;
    img[8]     = REVISION;
    img[9]     = PROG_IF;
    img[10]    = SUBCLASS;
    img[11]    = CLASS_CODE;
    img[12]    = cacheQ;
    img[13]    = latencyQ;
    img[14]    = HEADER_TYPE;
    img[15]    = SELF_TEST;
    for (int i = 0; i < NUM_BARS; i++) begin
      img[16 + 4*i +: 4] = barImg[i];
    end
    img[43:40] = CARDBUS_PTR;
    img[45:44] = SUBSYS_VENDOR;
    img[47:46] = SUBSYS_ID;
    img[51:48] = romQ;
    img[60]    = intLineQ;
    img[61]    = INT_PIN;
    img[62]    = MIN_GRANT;
    img[63]    = MAX_LATENCY;
  end

  logic [OFF_W-1:0] off1, off2, off3;
  logic [31:0]      rawWord;
  logic [31:0]      laneMask;

  assign off1 = strobe.rdOff + OFF_W'(1);
  assign off2 = strobe.rdOff + OFF_W'(2);
  assign off3 = strobe.rdOff + OFF_W'(3);
  assign rawWord = {img[off3], img[off2], img[off1], img[strobe.rdOff]};

  always_comb begin
    case (accSize_e'(strobe.rdSize))
      SZ_BYTE: laneMask = 32'h0000_00FF;
      SZ_HALF: laneMask = 32'h0000_FFFF;
      default: laneMask = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgRdata   <= 32'd0;
      cfgRdValid <= 1'b0;
    end else begin
      cfgRdValid <= strobe.rdFire;
      if (strobe.rdFire) cfgRdata <= strobe.rdOk ? (rawWord & laneMask) : 32'd0;
    end
  end

endmodule

// File: rtl/cfg_hdr_top.sv
module cfg_hdr_top
  import cfg_hdr_pkg::*;
#(
  parameter int          ADDR_W        = 8,
  parameter logic [15:0] VENDOR_ID     = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID     = 16'h0001,
  parameter logic [7:0]  REVISION      = 8'h00,
  parameter logic [7:0]  PROG_IF       = 8'h00,
  parameter logic [7:0]  SUBCLASS      = 8'h00,
  parameter logic [7:0]  CLASS_CODE    = 8'h00,
  parameter logic [7:0]  HEADER_TYPE   = 8'h00,
  parameter logic [7:0]  SELF_TEST     = 8'h00,
  parameter logic [31:0] CARDBUS_PTR   = 32'h0,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h0,
  parameter logic [15:0] SUBSYS_ID     = 16'h0,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [7:0]  MIN_GRANT     = 8'h00,
  parameter logic [7:0]  MAX_LATENCY   = 8'h00,
  parameter logic [15:0] COMMAND_INIT  = 16'h0,
  parameter logic [15:0] STATUS_INIT   = 16'h0,
  parameter logic [7:0]  CACHE_INIT    = 8'h00,
  parameter logic [7:0]  LATENCY_INIT  = 8'h00,
  parameter logic [7:0]  INTLINE_INIT  = 8'h00,
  parameter logic [31:0] ROM_INIT      = 32'h0,
  parameter logic [NUM_BARS-1:0][31:0] BAR_INIT = '0,
  parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [1:0]        cfgSize,
  input  logic [31:0]       cfgWdata,
  input  logic              cfgWrEn,
  input  logic              cfgRdEn,
  output logic [31:0]       cfgRdata,
  output logic              cfgRdValid,
  output logic              rangeChg
);

  hdrStrobe_t strobe;

  cfg_hdr_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .cfgAddr (cfgAddr),
    .cfgSize (cfgSize),
    .cfgWrEn (cfgWrEn),
    .cfgRdEn (cfgRdEn),
    .strobe  (strobe)
  );

  cfg_hdr_dpath #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REVISION(REVISION),
    .PROG_IF(PROG_IF), .SUBCLASS(SUBCLASS), .CLASS_CODE(CLASS_CODE),
    .HEADER_TYPE(HEADER_TYPE), .SELF_TEST(SELF_TEST), .CARDBUS_PTR(CARDBUS_PTR),
    .SUBSYS_VENDOR(SUBSYS_VENDOR), .SUBSYS_ID(SUBSYS_ID), .INT_PIN(INT_PIN),
    .MIN_GRANT(MIN_GRANT), .MAX_LATENCY(MAX_LATENCY), .COMMAND_INIT(COMMAND_INIT),
    .STATUS_INIT(STATUS_INIT), .CACHE_INIT(CACHE_INIT), .LATENCY_INIT(LATENCY_INIT),
    .INTLINE_INIT(INTLINE_INIT), .ROM_INIT(ROM_INIT), .BAR_INIT(BAR_INIT),
    .BAR_SIZE(BAR_SIZE)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgWdata   (cfgWdata),
    .cfgRdata   (cfgRdata),
    .cfgRdValid (cfgRdValid),
    .rangeChg   (rangeChg)
  );

endmodule

// File: rtl/cfg_hdr_chk.sv
module cfg_hdr_chk #(
  parameter int          ADDR_W    = 8,
  parameter logic [15:0] VENDOR_ID = 16'h0,
  parameter logic [15:0] DEVICE_ID = 16'h0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [1:0]        cfgSize,
  input logic [31:0]       cfgWdata,
  input logic              cfgWrEn,
  input logic              cfgRdEn,
  input logic [31:0]       cfgRdata,
  input logic              cfgRdValid,
  input logic              rangeChg
);

  logic badAlign;
  assign badAlign = (cfgSize == 2'd3) ||
                    (cfgSize == 2'd1 && cfgAddr[0]) ||
                    (cfgSize == 2'd2 && cfgAddr[1:0] != 2'b00);

  // R2: valid follows each read strobe by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdEn |=> cfgRdValid);

  // R2: no valid without a read strobe
  a_r2_no_stray_valid: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdEn |=> !cfgRdValid);

  // R2: byte reads leave the upper lanes zero
  a_r2_byte_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdEn && cfgSize == 2'd0) |=> (cfgRdata[31:8] == 24'd0));

  // R3: reads above the header return zero
  a_r3_region_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdEn && cfgAddr >= ADDR_W'(64)) |=> (cfgRdata == 32'd0));

  // R3: misaligned or invalid-size reads return zero
  a_r3_misaligned_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdEn && badAlign) |=> (cfgRdata == 32'd0));

  // R1: identification word is constant
  a_r1_ids_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdEn && cfgAddr == ADDR_W'(0) && cfgSize == 2'd2) |=> (cfgRdata == {DEVICE_ID, VENDOR_ID}));

  // R9: a pulse only follows a non-sizing word write
  a_r9_pulse_source: assert property (@(posedge clk) disable iff (!rstN)
    rangeChg |-> ($past(cfgWrEn) && $past(cfgSize) == 2'd2 && $past(cfgWdata) != 32'hFFFF_FFFF));

  // R9: narrow writes never pulse
  a_r9_narrow_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSize != 2'd2) |=> !rangeChg);

endmodule

bind cfg_hdr_top cfg_hdr_chk #(
  .ADDR_W(ADDR_W), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)
) uChk (
  .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgSize(cfgSize),
  .cfgWdata(cfgWdata), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
  .cfgRdata(cfgRdata), .cfgRdValid(cfgRdValid), .rangeChg(rangeChg)
);

// File: tb/sim_cfg_hdr_top.sv
module sim_cfg_hdr_top;

  localparam int CLK_PERIOD = 10;

  localparam logic [15:0] P_VID    = 16'h1D0F;
  localparam logic [15:0] P_DID    = 16'hBEE5;
  localparam logic [7:0]  P_REV    = 8'h03;
  localparam logic [7:0]  P_PIF    = 8'h11;
  localparam logic [7:0]  P_SUB    = 8'h02;
  localparam logic [7:0]  P_CLS    = 8'h06;
  localparam logic [7:0]  P_HDR    = 8'h00;
  localparam logic [7:0]  P_BIST   = 8'h00;
  localparam logic [31:0] P_CB     = 32'h0000_0040;
  localparam logic [15:0] P_SSV    = 16'h5A5A;
  localparam logic [15:0] P_SSI    = 16'hC3C3;
  localparam logic [7:0]  P_IPIN   = 8'h01;
  localparam logic [7:0]  P_MGNT   = 8'h10;
  localparam logic [7:0]  P_MLAT   = 8'h20;
  localparam logic [15:0] P_CMD    = 16'h0000;
  localparam logic [15:0] P_STAT   = 16'h0010;
  localparam logic [7:0]  P_CACHE  = 8'h00;
  localparam logic [7:0]  P_LAT    = 8'h40;
  localparam logic [7:0]  P_ILINE  = 8'hFF;
  localparam logic [31:0] P_ROM    = 32'h0;
  localparam logic [5:0][31:0] P_BAR_INIT = {32'h0, 32'h1, 32'h0, 32'h8, 32'h0, 32'h1};
  localparam logic [5:0][31:0] P_BAR_SIZE = {32'h0010_0000, 32'h20, 32'h0, 32'h0001_0000, 32'h1000, 32'h100};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [1:0]  cfgSize = '0;
  logic [31:0] cfgWdata = '0;
  logic        cfgWrEn = 1'b0;
  logic        cfgRdEn = 1'b0;
  logic [31:0] cfgRdata;
  logic        cfgRdValid;
  logic        rangeChg;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [7:0] mImg [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_hdr_top #(
    .ADDR_W(8), .VENDOR_ID(P_VID), .DEVICE_ID(P_DID), .REVISION(P_REV),
    .PROG_IF(P_PIF), .SUBCLASS(P_SUB), .CLASS_CODE(P_CLS), .HEADER_TYPE(P_HDR),
    .SELF_TEST(P_BIST), .CARDBUS_PTR(P_CB), .SUBSYS_VENDOR(P_SSV), .SUBSYS_ID(P_SSI),
    .INT_PIN(P_IPIN), .MIN_GRANT(P_MGNT), .MAX_LATENCY(P_MLAT), .COMMAND_INIT(P_CMD),
    .STATUS_INIT(P_STAT), .CACHE_INIT(P_CACHE), .LATENCY_INIT(P_LAT),
    .INTLINE_INIT(P_ILINE), .ROM_INIT(P_ROM), .BAR_INIT(P_BAR_INIT), .BAR_SIZE(P_BAR_SIZE)
  ) u0 (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgSize(cfgSize),
    .cfgWdata(cfgWdata), .cfgWrEn(cfgWrEn), .cfgRdEn(cfgRdEn),
    .cfgRdata(cfgRdata), .cfgRdValid(cfgRdValid), .rangeChg(rangeChg)
  );

  task automatic putWord(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mImg[a+k] = v[8*k +: 8];
  endtask

  function automatic logic [31:0] getWord(input int a);
    return {mImg[a+3], mImg[a+2], mImg[a+1], mImg[a]};
  endfunction

  task automatic modelReset();
    for (int k = 0; k < 64; k++) mImg[k] = 8'h00;
    putWord(0, {P_DID, P_VID});
    putWord(4, {P_STAT, P_CMD});
    putWord(8, {P_CLS, P_SUB, P_PIF, P_REV});
    putWord(12, {P_BIST, P_HDR, P_LAT, P_CACHE});
    for (int b = 0; b < 6; b++) putWord(16 + 4*b, P_BAR_INIT[b]);
    putWord(40, P_CB);
    putWord(44, {P_SSI, P_SSV});
    putWord(48, P_ROM);
    putWord(60, {P_MLAT, P_MGNT, P_IPIN, P_ILINE});
  endtask

  function automatic bit legal(input int a, input int s);
    if (a >= 64 || s == 3) return 1'b0;
    if (s == 1 && (a % 2) != 0) return 1'b0;
    if (s == 2 && (a % 4) != 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic modelWrite(input int a, input int s, input logic [31:0] d, output logic pulse);
    pulse = 1'b0;
    if (!legal(a, s)) return;
    if (s == 0) begin
      if (a == 'h3C || a == 'h0C || a == 'h0D) mImg[a] = d[7:0];
    end else if (s == 1) begin
      if (a == 'h04 || a == 'h06) begin
        mImg[a] = d[7:0]; mImg[a+1] = d[15:8];
      end else if (a == 'h0C) mImg[a] = d[7:0];
    end else begin
      if (a == 'h04) begin
        mImg[4] = d[7:0]; mImg[5] = d[15:8];
      end else if (a >= 'h10 && a <= 'h24) begin
        logic [31:0] cur, m, nv;
        int bi;
        bi  = (a - 'h10) / 4;
        cur = getWord(a);
        m   = cur[0] ? 32'h3 : 32'hF;
        if (d == 32'hFFFF_FFFF) nv = (~(P_BAR_SIZE[bi] - 32'd1) & ~m) | (cur & m);
        else begin
          nv = (d & ~m) | (cur & m);
          pulse = ((nv & ~m) != 0);
        end
        putWord(a, nv);
      end else if (a == 'h30) begin
        putWord(a, (d == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : d);
      end
    end
  endtask

  function automatic logic [31:0] modelRead(input int a, input int s);
    if (!legal(a, s)) return 32'd0;
    if (s == 0) return {24'd0, mImg[a]};
    if (s == 1) return {16'd0, mImg[a+1], mImg[a]};
    return getWord(a);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic doWrite(input string req, input int a, input int s, input logic [31:0] d);
    logic expPulse;
    @(negedge clk);
    cfgAddr = 8'(a); cfgSize = 2'(s); cfgWdata = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    modelWrite(a, s, d, expPulse);
    check({req, " pulse"}, {31'd0, rangeChg}, {31'd0, expPulse});
  endtask

  task automatic doRead(input string req, input int a, input int s);
    @(negedge clk);
    cfgAddr = 8'(a); cfgSize = 2'(s); cfgRdEn = 1'b1;
    @(negedge clk);
    cfgRdEn = 1'b0;
    check({req, " valid"}, {31'd0, cfgRdValid}, 32'd1);
    check(req, cfgRdata, modelRead(a, s));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset pulse", {31'd0, rangeChg}, 32'd0);
    check("R2 reset valid", {31'd0, cfgRdValid}, 32'd0);

    // R1: reset image
    for (int a = 0; a < 64; a += 4) doRead("R1 reset word", a, 2);
    // R2: widths and lanes
    doRead("R2 byte 0x01", 1, 0);
    doRead("R2 half 0x02", 2, 1);
    doRead("R2 byte 0x3F", 'h3F, 0);
    // R3: out of region and misaligned
    doRead("R3 read 0x40", 'h40, 2);
    doRead("R3 read 0x80", 'h80, 0);
    doRead("R3 misaligned half", 3, 1);
    doRead("R3 misaligned word", 2, 2);
    doRead("R3 size code 3", 0, 3);
    doWrite("R3 word 0x12", 'h12, 2, 32'h1234_5670);
    doRead("R3 bar0 kept", 'h10, 2);
    doWrite("R3 bad size 0x3C", 'h3C, 3, 32'h0000_0077);
    doRead("R3 intline kept", 'h3C, 2);
    doWrite("R3 above region", 'h7C, 0, 32'h55);
    doRead("R3 image kept", 'h3C, 2);
    // R4: byte writes
    doWrite("R4 intline", 'h3C, 0, 32'hFFFF_FF5A);
    doRead("R4 intline word", 'h3C, 2);
    doWrite("R4 intpin ignored", 'h3D, 0, 32'h77);
    doRead("R4 intpin word", 'h3C, 2);
    doWrite("R4 cacheline", 'h0C, 0, 32'h08);
    doWrite("R4 latency", 'h0D, 0, 32'h80);
    doWrite("R4 revision ignored", 'h08, 0, 32'hEE);
    doRead("R4 word 0x0C", 'h0C, 2);
    doRead("R4 word 0x08", 'h08, 2);
    // R5: halfword writes
    doWrite("R5 half 0x0C", 'h0C, 1, 32'h0000_ABCD);
    doRead("R5 word 0x0C", 'h0C, 2);
    doWrite("R5 command", 'h04, 1, 32'h0000_0147);
    doWrite("R5 status", 'h06, 1, 32'h0000_2210);
    doRead("R5 word 0x04", 'h04, 2);
    doWrite("R5 half vendor ignored", 'h00, 1, 32'h0000_9999);
    doWrite("R5 half 0x3C ignored", 'h3C, 1, 32'h0000_1111);
    doRead("R5 word 0x00", 'h00, 2);
    doRead("R5 word 0x3C", 'h3C, 2);
    // R6: word writes
    doWrite("R6 word command", 'h04, 2, 32'hDEAD_0006);
    doRead("R6 word 0x04", 'h04, 2);
    doWrite("R6 word ids ignored", 'h00, 2, 32'h0BAD_0BAD);
    doWrite("R6 word class ignored", 'h08, 2, 32'h0BAD_0BAD);
    doWrite("R6 word subsys ignored", 'h2C, 2, 32'h0BAD_0BAD);
    doRead("R6 word 0x00", 'h00, 2);
    doRead("R6 word 0x08", 'h08, 2);
    doRead("R6 word 0x2C", 'h2C, 2);
    // R7/R8: sizing
    for (int b = 0; b < 6; b++) begin
      doWrite("R8 sizing", 'h10 + 4*b, 2, 32'hFFFF_FFFF);
      doRead("R8 sizing readback", 'h10 + 4*b, 2);
    end
    doRead("R7 bar0 io", 'h10, 2);
    check("R8 io size 0x100", modelRead('h10, 2), 32'hFFFF_FF01);
    check("R8 mem size 0x10000", modelRead('h18, 2), 32'hFFFF_0008);
    check("R8 zero size", modelRead('h1C, 2), 32'h0000_0000);
    // R9: address writes and pulse
    doWrite("R9 bar1 nonzero", 'h14, 2, 32'h1234_5677);
    @(negedge clk);
    check("R9 pulse one cycle", {31'd0, rangeChg}, 32'd0);
    doRead("R9 bar1", 'h14, 2);
    check("R7 bar1 type bits", modelRead('h14, 2), 32'h1234_5670);
    doWrite("R9 bar1 zero base", 'h14, 2, 32'h0000_000F);
    doRead("R9 bar1 zero", 'h14, 2);
    doWrite("R9 bar0 io", 'h10, 2, 32'h0000_C003);
    doRead("R7 bar0 io kept", 'h10, 2);
    doWrite("R9 rom no pulse", 'h30, 2, 32'h1000_0000);
    // R10: expansion ROM
    doWrite("R10 rom sizing", 'h30, 2, 32'hFFFF_FFFE);
    doRead("R10 rom ones", 'h30, 2);
    doWrite("R10 rom value", 'h30, 2, 32'h00AB_C001);
    doRead("R10 rom stored", 'h30, 2);

    // Random mix (R2, R3, R9)
    for (int n = 0; n < 600; n++) begin
      int a, s;
      logic [31:0] d;
      a = int'($urandom_range(0, 'h47));
      s = int'($urandom_range(0, 3));
      if (($urandom % 8) == 0) begin
        s = 2; a = a & 'h3C;
      end
      case ($urandom % 8)
        0: d = 32'hFFFF_FFFF;
        1: d = 32'hFFFF_FFFE;
        2: d = 32'h0000_0003;
        default: d = $urandom;
      endcase
      doWrite("R9 random write", a, s, d);
      doRead("R2 random read back", a & 'h3C, 2);
      doRead("R2 random read", int'($urandom_range(0, 'h47)), int'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule